// File: doc/BRIEF.md
# Boundary-Scan Bidirectional Pin Cell

This block is the boundary-scan cell for a single bidirectional digital I/O pin that has a pull-up. It sits between the core's port logic and the pad. In functional operation the core's direction bit drives the pad output enable and the core's port bit drives the pad output data. The pull-up is switched on only when the global pull-up disable is low, the pin is an input and the port bit is high. The raw pad level goes back to the core without a synchronizer.

For test, the pin is covered by a two-stage scan section. The control stage captures the direction bit. The data stage captures the actual pad level. A separate single-stage standard cell covers the pull-up enable. All three stages form one chain: scan_in feeds the pull-up stage, then the control stage, then the data stage, which drives scan_out.

Capture, shift and update are enables sampled on the test clock. Update copies the stages into output latches. When test mode is selected, those latches drive the pad in place of the functional signals. The latches hold their values while data is shifted, so the pad does not toggle during a scan load.

Top module: `bscan_io_cell`

## Requirements
- R1: While rst_n is low, every shift stage and every update latch is 0, for the default latch reset value of 0. After reset with test_mode high, pad_oe, pad_out, pad_pullup and scan_out are all 0.
- R2: With test_mode low, pad_oe equals core_dir and pad_out equals core_port in the same cycle.
- R3: With test_mode low, pad_pullup is 1 exactly when core_pud is 0, core_dir is 0 and core_port is 1.
- R4: core_in equals pad_in combinationally at all times, with no register in the path.
- R5: A clock edge with capture_en high loads three values into the stages: the functional pull-up enable (as in R3) into the pull-up stage, core_dir into the control stage and pad_in into the data stage. scan_out then shows the captured pad level.
- R6: A clock edge with shift_en high and capture_en low moves the chain one place. The pull-up stage takes scan_in, the control stage takes the old pull-up stage and the data stage takes the old control stage. scan_out always shows the data stage, so a bit on scan_in reaches scan_out after three shift edges.
- R7: When capture_en and shift_en are both high, the capture of R5 takes place and the shift does not.
- R8: A clock edge with update_en high copies the stage values present before that edge into the latches. With test_mode high, pad_oe shows the control latch, pad_out shows the data latch and pad_pullup shows the pull-up latch.
- R9: Without update_en, the latches and therefore the test-mode pad outputs stay unchanged, whatever capture or shift does.
- R10: A clock edge with neither capture_en nor shift_en leaves all three stages unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_en | input | 1 | Load the stages from the functional and pad values |
| shift_en | input | 1 | Move the chain one place toward scan_out |
| update_en | input | 1 | Copy the stages into the output latches |
| test_mode | input | 1 | 1 selects the latches to drive the pad |
| scan_in | input | 1 | Serial data into the pull-up stage |
| scan_out | output | 1 | Serial data from the data stage |
| core_dir | input | 1 | Core direction bit, 1 means output |
| core_port | input | 1 | Core port data bit |
| core_pud | input | 1 | Global pull-up disable |
| pad_in | input | 1 | Level seen at the pad |
| core_in | output | 1 | Pad level returned to the core |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output data |
| pad_pullup | output | 1 | Pad pull-up enable |

## Verification
The pad-side outputs and core_in are combinational, so they are due in the same cycle as the inputs that select them. The stages and latches change one edge after capture, shift or update is sampled. scan_out therefore shows a captured pad level one edge after capture, and a bit on scan_in three shift edges after it enters. The bench drives inputs shortly after each falling edge. It compares every output with a behavioural model on the next falling edge, which comes after the model and the design have both taken the rising edge. The directed checks sample at that same point.

// File: rtl/bscan_cell_pkg.sv
package bscan_cell_pkg;

    localparam int PIN_STAGES = 2;
    localparam int PU_STAGES  = 1;
    localparam int CHAIN_LEN  = PIN_STAGES + PU_STAGES;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } scan_op_t;

    typedef struct packed {
        logic ctl_sr;
        logic dat_sr;
        logic ctl_up;
        logic dat_up;
    } pin_state_t;

    typedef struct packed {
        logic sr;
        logic up;
    } pu_state_t;

    // capture wins over shift
    function automatic scan_op_t decode_op(input logic cap, input logic sh);
        if (cap)      return OP_CAPTURE;
        else if (sh)  return OP_SHIFT;
        else          return OP_HOLD;
    endfunction

endpackage

// File: rtl/bscan_pu_cell.sv
module bscan_pu_cell
    import bscan_cell_pkg::*;
#(
    parameter logic UP_RST = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  scan_op_t op,
    input  logic     upd_en,
    input  logic     cap_val,
    input  logic     ser_in,
    output logic     sr_o,
    output logic     up_o
);

    pu_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (op)
            OP_CAPTURE: st_d.sr = cap_val;
            OP_SHIFT:   st_d.sr = ser_in;
            default:    st_d.sr = st_q.sr;
        endcase
        if (upd_en) begin
            st_d.up = st_q.sr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sr: 1'b0, up: UP_RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_o = st_q.sr;
    assign up_o = st_q.up;

endmodule

// File: rtl/bscan_pin_cell.sv
module bscan_pin_cell
    import bscan_cell_pkg::*;
#(
    parameter logic CTL_RST = 1'b0,
    parameter logic DAT_RST = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  scan_op_t op,
    input  logic     upd_en,
    input  logic     ctl_cap,
    input  logic     dat_cap,
    input  logic     ser_in,
    output logic     ctl_sr_o,
    output logic     dat_sr_o,
    output logic     ctl_up_o,
    output logic     dat_up_o
);

    pin_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (op)
            OP_CAPTURE: begin
                st_d.ctl_sr = ctl_cap;
                st_d.dat_sr = dat_cap;
            end
            OP_SHIFT: begin
                st_d.ctl_sr = ser_in;
                st_d.dat_sr = st_q.ctl_sr;
            end
            default: begin
                st_d.ctl_sr = st_q.ctl_sr;
                st_d.dat_sr = st_q.dat_sr;
            end
        endcase
        if (upd_en) begin
            st_d.ctl_up = st_q.ctl_sr;
            st_d.dat_up = st_q.dat_sr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctl_sr: 1'b0, dat_sr: 1'b0, ctl_up: CTL_RST, dat_up: DAT_RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_sr_o = st_q.ctl_sr;
    assign dat_sr_o = st_q.dat_sr;
    assign ctl_up_o = st_q.ctl_up;
    assign dat_up_o = st_q.dat_up;

endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux (
    input  logic test_mode,
    input  logic core_dir,
    input  logic core_port,
    input  logic core_pud,
    input  logic tst_oe,
    input  logic tst_out,
    input  logic tst_pu,
    output logic func_pu,
    output logic pad_oe,
    output logic pad_out,
    output logic pad_pullup
);

    always_comb begin
        func_pu = !core_pud && !core_dir && core_port;
        if (test_mode) begin
            pad_oe     = tst_oe;
            pad_out    = tst_out;
            pad_pullup = tst_pu;
        end else begin
            pad_oe     = core_dir;
            pad_out    = core_port;
            pad_pullup = func_pu;
        end
    end

endmodule

// File: rtl/bscan_io_cell.sv
module bscan_io_cell
    import bscan_cell_pkg::*;
#(
    parameter logic [CHAIN_LEN-1:0] UPD_RST = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic capture_en,
    input  logic shift_en,
    input  logic update_en,
    input  logic test_mode,
    input  logic scan_in,
    output logic scan_out,
    input  logic core_dir,
    input  logic core_port,
    input  logic core_pud,
    input  logic pad_in,
    output logic core_in,
    output logic pad_oe,
    output logic pad_out,
    output logic pad_pullup
);

    scan_op_t op;
    logic     func_pu;
    logic     pu_sr, pu_up;
    logic     ctl_sr, dat_sr, ctl_up, dat_up;
    logic [CHAIN_LEN-1:0] shift_stages;
    logic [CHAIN_LEN-1:0] upd_latches;

    assign op = decode_op(capture_en, shift_en);

    bscan_pu_cell #(
        .UP_RST (UPD_RST[2])
    ) u_pu (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .upd_en  (update_en),
        .cap_val (func_pu),
        .ser_in  (scan_in),
        .sr_o    (pu_sr),
        .up_o    (pu_up)
    );

    bscan_pin_cell #(
        .CTL_RST (UPD_RST[1]),
        .DAT_RST (UPD_RST[0])
    ) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .upd_en   (update_en),
        .ctl_cap  (core_dir),
        .dat_cap  (pad_in),
        .ser_in   (pu_sr),
        .ctl_sr_o (ctl_sr),
        .dat_sr_o (dat_sr),
        .ctl_up_o (ctl_up),
        .dat_up_o (dat_up)
    );

    bscan_pad_mux u_mux (
        .test_mode  (test_mode),
        .core_dir   (core_dir),
        .core_port  (core_port),
        .core_pud   (core_pud),
        .tst_oe     (ctl_up),
        .tst_out    (dat_up),
        .tst_pu     (pu_up),
        .func_pu    (func_pu),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pad_pullup (pad_pullup)
    );

    assign scan_out     = dat_sr;
    assign core_in      = pad_in;
    assign shift_stages = {pu_sr, ctl_sr, dat_sr};
    assign upd_latches  = {pu_up, ctl_up, dat_up};

endmodule

// File: rtl/bscan_io_cell_chk.sv
module bscan_io_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       capture_en,
    input logic       shift_en,
    input logic       update_en,
    input logic       test_mode,
    input logic       scan_in,
    input logic       scan_out,
    input logic       core_dir,
    input logic       core_port,
    input logic       core_pud,
    input logic       pad_in,
    input logic       core_in,
    input logic       pad_oe,
    input logic       pad_out,
    input logic       pad_pullup,
    input logic [2:0] shift_stages,
    input logic [2:0] upd_latches
);

    p_func_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> (pad_oe == core_dir && pad_out == core_port));

    p_func_pullup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> (pad_pullup == (!core_pud && !core_dir && core_port)));

    p_core_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        core_in == pad_in);

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> shift_stages == {$past(!core_pud && !core_dir && core_port),
                                        $past(core_dir), $past(pad_in)});

    p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !capture_en) |=> shift_stages == {$past(scan_in), $past(shift_stages[2:1])});

    p_scan_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_out == shift_stages[0]);

    p_capture_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && shift_en) |=> scan_out == $past(pad_in));

    p_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
        update_en |=> upd_latches == $past(shift_stages));

    p_test_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (pad_oe == upd_latches[1] && pad_out == upd_latches[0]
                       && pad_pullup == upd_latches[2]));

    p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !update_en |=> $stable(upd_latches));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_en && !shift_en) |=> $stable(shift_stages));

endmodule

bind bscan_io_cell bscan_io_cell_chk u_chk (.*);

// File: tb/tb_bscan_io_cell.sv
module tb_bscan_io_cell;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, test_mode = 1'b0;
    logic scan_in = 1'b0, core_dir = 1'b0, core_port = 1'b0, core_pud = 1'b0, pad_in = 1'b0;
    logic scan_out, core_in, pad_oe, pad_out, pad_pullup;

    int checks = 0;
    int fails  = 0;
    bit started = 0;

    // model state: chain[0]=pull-up stage, [1]=control, [2]=data
    bit chain[$] = '{0, 0, 0};
    bit m_pu_up = 0, m_ctl_up = 0, m_dat_up = 0;

    always #2 clk = ~clk;

    bscan_io_cell dut (
        .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .test_mode(test_mode), .scan_in(scan_in),
        .scan_out(scan_out), .core_dir(core_dir), .core_port(core_port),
        .core_pud(core_pud), .pad_in(pad_in), .core_in(core_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pullup(pad_pullup)
    );

    function automatic bit want_pu(bit pud, bit dir, bit port);
        return (pud == 0) && (dir == 0) && (port == 1);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain = '{0, 0, 0};
            m_pu_up = 0; m_ctl_up = 0; m_dat_up = 0;
        end else begin
            bit o_pu, o_ctl, o_dat;
            o_pu = chain[0]; o_ctl = chain[1]; o_dat = chain[2];
            if (capture_en) begin
                chain = '{want_pu(core_pud, core_dir, core_port), core_dir, pad_in};
            end else if (shift_en) begin
                chain.push_front(scan_in);
                void'(chain.pop_back());
            end
            if (update_en) begin
                m_pu_up = o_pu; m_ctl_up = o_ctl; m_dat_up = o_dat;
            end
        end
    end

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (started && rst_n) begin
            check("R4", "core_in", core_in, pad_in);
            check("R6", "scan_out", scan_out, chain[2]);
            if (test_mode) begin
                check("R8", "pad_oe", pad_oe, m_ctl_up);
                check("R8", "pad_out", pad_out, m_dat_up);
                check("R8", "pad_pullup", pad_pullup, m_pu_up);
            end else begin
                check("R2", "pad_oe", pad_oe, core_dir);
                check("R2", "pad_out", pad_out, core_port);
                check("R3", "pad_pullup", pad_pullup, want_pu(core_pud, core_dir, core_port));
            end
        end
    end

    task automatic drive(bit cap, bit sh, bit up, bit si);
        @(negedge clk);
        #1;
        capture_en = cap; shift_en = sh; update_en = up; scan_in = si;
    endtask

    task automatic set_core(bit dir, bit port, bit pud, bit pin);
        core_dir = dir; core_port = port; core_pud = pud; pad_in = pin;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        started = 1;
        test_mode = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "pad_oe after reset", pad_oe, 1'b0);
        check("R1", "pad_out after reset", pad_out, 1'b0);
        check("R1", "pad_pullup after reset", pad_pullup, 1'b0);
        check("R1", "scan_out after reset", scan_out, 1'b0);

        // R5 capture: pad high, direction output
        #1 set_core(1, 0, 0, 1);
        drive(1, 0, 0, 0);
        drive(0, 1, 0, 0);
        check("R5", "captured pad level", scan_out, 1'b1);
        drive(0, 1, 0, 0);
        check("R5", "captured direction", scan_out, 1'b1);
        drive(0, 0, 0, 0);
        check("R5", "captured pull-up enable", scan_out, 1'b0);

        // R5 second pattern: input with pull-up
        #1 set_core(0, 1, 0, 0);
        drive(1, 0, 0, 0);
        drive(0, 1, 0, 0);
        check("R5", "captured pad low", scan_out, 1'b0);
        drive(0, 1, 0, 0);
        check("R5", "captured direction in", scan_out, 1'b0);
        drive(0, 0, 0, 0);
        check("R5", "captured pull-up on", scan_out, 1'b1);

        // R6 three-edge latency, then R9 latches hold across shifts
        drive(0, 1, 0, 1);
        drive(0, 1, 0, 0);
        drive(0, 1, 0, 1);
        drive(0, 0, 0, 0);
        check("R6", "scan_in after three shifts", scan_out, 1'b1);
        check("R9", "pad_oe held during shift", pad_oe, 1'b0);
        check("R9", "pad_out held during shift", pad_out, 1'b0);
        // R10 idle cycles keep the stages
        drive(0, 0, 0, 0);
        drive(0, 0, 0, 0);
        check("R10", "stage kept while idle", scan_out, 1'b1);
        // R8 update: stages are pu=1, ctl=0, dat=1
        drive(0, 0, 1, 0);
        drive(0, 0, 0, 0);
        check("R8", "pad_out from latch", pad_out, 1'b1);
        check("R8", "pad_oe from latch", pad_oe, 1'b0);
        check("R8", "pad_pullup from latch", pad_pullup, 1'b1);

        // R7 capture over shift
        #1 set_core(1, 1, 1, 0);
        drive(1, 1, 0, 1);
        drive(0, 0, 0, 0);
        check("R7", "capture beats shift", scan_out, 1'b0);

        // random traffic compared against the model every cycle
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            #1;
            capture_en = ($urandom % 4) == 0;
            shift_en   = ($urandom % 2) == 0;
            update_en  = ($urandom % 5) == 0;
            test_mode  = ($urandom % 3) != 0;
            scan_in    = $urandom;
            core_dir   = $urandom; core_port = $urandom;
            core_pud   = $urandom; pad_in    = $urandom;
        end

        // R1 again: reset mid-run clears latches
        @(negedge clk);
        #1 rst_n = 1'b0; test_mode = 1'b1;
        capture_en = 0; shift_en = 0; update_en = 0;
        @(negedge clk);
        check("R1", "pad_oe in reset", pad_oe, 1'b0);
        check("R1", "pad_pullup in reset", pad_pullup, 1'b0);
        check("R1", "scan_out in reset", scan_out, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule